// File: doc/BRIEF.md
# Remote-Control Key Code Lookup

This block turns a decoded infrared remote frame into a key code. Each frame arrives as a 16-bit user code and an 8-bit scan code. A table loaded by software maps these to key codes. The table is split into a few user-code groups. Each group holds a programmable number of button slots, and each slot pairs a scan code with a key code.

A lookup runs in two stages. First the groups are compared one by one against the requested user code. Then the button slots of the first matching group are compared one by one against the scan code. The block returns the key code with a hit flag, or the reserved "no key" value 0 on a miss.

The block also counts repeats. Each hit is compared with the key reported before it, so a held button produces a rising repeat count that stops at its maximum value. A single-cycle done pulse marks each new result. Busy is high while a search is in progress.

Top module: `irKeymap`

## Requirements
- R1: After reset, busy, done and hit are 0, keyCode is 0 and repeatCnt is 0. Every group is empty, with user code 0 and a button count of 0.
- R2: A write with cfgWe high takes effect at the clock edge and targets group cfgGroup. The value of cfgKind selects what is written:
  - 0 writes the group user code from cfgData[15:0].
  - 1 writes the button count from cfgData. A value above 16 is stored as 16.
  - 2 writes slot cfgSlot, with the scan code from cfgData[7:0] and the key code from cfgData[17:8].
  - 3 changes nothing.
- R3: A user-code write whose data is 0 is ignored, so the group keeps its previous user code. A group whose user code is 0 never matches, including a request for user code 0.
- R4: Groups are searched in ascending index order, and only the first group whose user code equals reqUser is searched for the scan code. In that group only slots below its button count are considered, in ascending slot order. Slots at or above the count are never matched.
- R5: On a hit, keyCode becomes the matching slot's key code and hit becomes 1.
- R6: On a hit whose key code equals the keyCode reported before it, repeatCnt increments by one and saturates at 255. On a hit with any other key code, repeatCnt becomes 0.
- R7: On a miss (no matching group, or no matching slot in that group), keyCode becomes 0, repeatCnt becomes 0 and hit becomes 0.
- R8: A request is accepted when reqValid is high at a clock edge while busy is 0. Busy rises at that edge. Busy falls, and done pulses high for exactly one cycle, at the edge that updates the results. Counting edges after the accepting edge, that edge comes at:
  - (g+1)+(j+1) for a hit in group g, slot j.
  - (g+1)+(c+1) for a scan-code miss in group g with button count c.
  - 4 when no group matches.
- R9: reqValid is ignored while busy is 1. The search in progress completes with its original user and scan codes, and only one done pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfgWe | input | 1 | Table write strobe |
| cfgKind | input | 2 | Write kind: 0 user code, 1 button count, 2 slot, 3 none |
| cfgGroup | input | 2 | Target group of a write |
| cfgSlot | input | 4 | Target slot of a slot write |
| cfgData | input | 18 | Write data (user code, count, or key code and scan code) |
| reqValid | input | 1 | Lookup request |
| reqUser | input | 16 | Requested user code |
| reqScan | input | 8 | Requested scan code |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when a new result is valid |
| hit | output | 1 | Last result matched a table slot |
| keyCode | output | 10 | Last reported key code, 0 on a miss |
| repeatCnt | output | 8 | Consecutive-repeat count of the last key |

## Verification
The assertions assume that the table is not rewritten while a search is running. A write to the group or slot under comparison would otherwise change the outcome part way through the search. They also assume reqValid is a clean level sampled at the clock edge. The bench meets both assumptions: every table write is issued while busy is low, and all inputs are driven on the falling edge. Requests made while busy are raised on purpose only to show that they are ignored.

// File: rtl/irKeymapPkg.sv
package irKeymapPkg;

  // Table write selector
  typedef enum logic [1:0] {
    CFG_USER  = 2'd0,
    CFG_COUNT = 2'd1,
    CFG_SLOT  = 2'd2,
    CFG_NONE  = 2'd3
  } cfgKind_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic latchReq;
    logic grpClr;
    logic grpInc;
    logic btnClr;
    logic btnInc;
    logic commitHit;
    logic commitMiss;
  } strobes_t;

  // Compare results from the datapath to the sequencer
  typedef struct packed {
    logic grpMatch;
    logic grpLast;
    logic btnEnd;
    logic btnMatch;
  } flags_t;

endpackage

// File: rtl/irKeymapCtrl.sv
module irKeymapCtrl
  import irKeymapPkg::*;
#(
  parameter int NUM_GROUPS  = 4,
  parameter int MAX_BUTTONS = 16
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     reqValid,
  input  flags_t   flags,
  output strobes_t strobes,
  output logic     busy
);

  localparam int BUSY_LIMIT = NUM_GROUPS + MAX_BUTTONS + 1;
  localparam int BC_W       = $clog2(BUSY_LIMIT + 2);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GRP  = 2'd1,
    ST_BTN  = 2'd2
  } state_e;

  state_e state, stateNext;

  always_comb begin
    strobes   = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobes.latchReq = 1'b1;
          strobes.grpClr   = 1'b1;
          stateNext        = ST_GRP;
        end
      end
      ST_GRP: begin
        if (flags.grpMatch) begin
          strobes.btnClr = 1'b1;
          stateNext      = ST_BTN;
        end else if (flags.grpLast) begin
          strobes.commitMiss = 1'b1;
          stateNext          = ST_IDLE;
        end else begin
          strobes.grpInc = 1'b1;
        end
      end
      ST_BTN: begin
        if (flags.btnEnd) begin
          strobes.commitMiss = 1'b1;
          stateNext          = ST_IDLE;
        end else if (flags.btnMatch) begin
          strobes.commitHit = 1'b1;
          stateNext         = ST_IDLE;
        end else begin
          strobes.btnInc = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  assign busy = (state != ST_IDLE);

  // Length of the current busy stretch, for the bound check below
  logic [BC_W-1:0] busyCycles;
  always_ff @(posedge clk) begin
    if (rst || !busy)                    busyCycles <= '0;
    else if (busyCycles != {BC_W{1'b1}}) busyCycles <= busyCycles + 1'b1;
  end

  // R8
  busy_bound_chk: assert property (@(posedge clk) disable iff (rst)
    busyCycles <= BC_W'(BUSY_LIMIT));

  // R8
  start_req_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(reqValid));

endmodule

// File: rtl/irKeymapData.sv
module irKeymapData
  import irKeymapPkg::*;
#(
  parameter int NUM_GROUPS  = 4,
  parameter int MAX_BUTTONS = 16,
  parameter int USER_W      = 16,
  parameter int SCAN_W      = 8,
  parameter int KEY_W       = 10,
  parameter int REP_W       = 8,
  localparam int GRP_W      = $clog2(NUM_GROUPS),
  localparam int IDX_W      = $clog2(MAX_BUTTONS),
  localparam int CNT_W      = $clog2(MAX_BUTTONS + 1),
  localparam int CFG_W      = (USER_W > SCAN_W + KEY_W) ? USER_W : SCAN_W + KEY_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgWe,
  input  logic [1:0]        cfgKind,
  input  logic [GRP_W-1:0]  cfgGroup,
  input  logic [IDX_W-1:0]  cfgSlot,
  input  logic [CFG_W-1:0]  cfgData,
  input  logic [USER_W-1:0] reqUser,
  input  logic [SCAN_W-1:0] reqScan,
  input  strobes_t          strobes,
  output flags_t            flags,
  output logic              done,
  output logic              hit,
  output logic [KEY_W-1:0]  keyCode,
  output logic [REP_W-1:0]  repeatCnt
);

  localparam logic [REP_W-1:0] REP_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_BUTTONS);

  // Table storage
  logic [USER_W-1:0] grpUser  [NUM_GROUPS];
  logic [CNT_W-1:0]  grpCount [NUM_GROUPS];
  logic [SCAN_W-1:0] slotScan [NUM_GROUPS][MAX_BUTTONS];
  logic [KEY_W-1:0]  slotKey  [NUM_GROUPS][MAX_BUTTONS];

  logic [USER_W-1:0] cfgUser;
  logic [CNT_W-1:0]  cfgCount;
  assign cfgUser  = cfgData[USER_W-1:0];
  assign cfgCount = (cfgData > CFG_W'(MAX_BUTTONS)) ? CNT_MAX : cfgData[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int g = 0; g < NUM_GROUPS; g++) begin
        grpUser[g]  <= '0;
        grpCount[g] <= '0;
        for (int s = 0; s < MAX_BUTTONS; s++) begin
          slotScan[g][s] <= '0;
          slotKey[g][s]  <= '0;
        end
      end
    end else if (cfgWe) begin
      unique case (cfgKind_e'(cfgKind))
        CFG_USER:  if (cfgUser != '0) grpUser[cfgGroup] <= cfgUser;
        CFG_COUNT: grpCount[cfgGroup] <= cfgCount;
        CFG_SLOT: begin
          slotScan[cfgGroup][cfgSlot] <= cfgData[SCAN_W-1:0];
          slotKey[cfgGroup][cfgSlot]  <= cfgData[SCAN_W +: KEY_W];
        end
        default: ;
      endcase
    end
  end

  // Latched request and search cursors
  logic [USER_W-1:0] userQ;
  logic [SCAN_W-1:0] scanQ;
  logic [GRP_W-1:0]  grpIdx;
  logic [CNT_W-1:0]  btnIdx;

  always_ff @(posedge clk) begin
    if (rst) begin
      userQ  <= '0;
      scanQ  <= '0;
      grpIdx <= '0;
      btnIdx <= '0;
    end else begin
      if (strobes.latchReq) begin
        userQ <= reqUser;
        scanQ <= reqScan;
      end
      if (strobes.grpClr)      grpIdx <= '0;
      else if (strobes.grpInc) grpIdx <= grpIdx + 1'b1;
      if (strobes.btnClr)      btnIdx <= '0;
      else if (strobes.btnInc) btnIdx <= btnIdx + 1'b1;
    end
  end

  // Per-group user-code comparators
  logic [NUM_GROUPS-1:0] grpHitVec;
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gen_grpCmp
    assign grpHitVec[g] = (grpUser[g] != '0) && (grpUser[g] == userQ);
  end

  logic [IDX_W-1:0]  slotSel;
  logic [KEY_W-1:0]  selKey;
  logic [SCAN_W-1:0] selScan;
  assign slotSel = btnIdx[IDX_W-1:0];
  assign selScan = slotScan[grpIdx][slotSel];
  assign selKey  = slotKey[grpIdx][slotSel];

  always_comb begin
    flags          = '0;
    flags.grpMatch = grpHitVec[grpIdx];
    flags.grpLast  = (grpIdx == GRP_W'(NUM_GROUPS - 1));
    flags.btnEnd   = (btnIdx >= grpCount[grpIdx]);
    flags.btnMatch = (selScan == scanQ);
  end

  // Result registers
  logic [KEY_W-1:0] keyQ;
  logic [REP_W-1:0] repQ;
  logic             hitQ;
  logic             doneQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      keyQ  <= '0;
      repQ  <= '0;
      hitQ  <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= strobes.commitHit | strobes.commitMiss;
      if (strobes.commitHit) begin
        hitQ <= 1'b1;
        keyQ <= selKey;
        if (selKey != keyQ)      repQ <= '0;
        else if (repQ != REP_MAX) repQ <= repQ + 1'b1;
      end else if (strobes.commitMiss) begin
        hitQ <= 1'b0;
        keyQ <= '0;
        repQ <= '0;
      end
    end
  end

  assign done      = doneQ;
  assign hit       = hitQ;
  assign keyCode   = keyQ;
  assign repeatCnt = repQ;

  // R6
  repeat_step_chk: assert property (@(posedge clk) disable iff (rst)
    doneQ |-> (repQ == '0) || (repQ == $past(repQ) + REP_W'(1)) ||
              (repQ == REP_MAX && $past(repQ) == REP_MAX));

  // R6
  new_key_chk: assert property (@(posedge clk) disable iff (rst)
    (doneQ && hitQ && keyQ != $past(keyQ)) |-> repQ == '0);

  // R7
  miss_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (doneQ && !hitQ) |-> (keyQ == '0 && repQ == '0));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    doneQ |=> !doneQ);

endmodule

// File: rtl/irKeymap.sv
module irKeymap
  import irKeymapPkg::*;
#(
  parameter int NUM_GROUPS  = 4,
  parameter int MAX_BUTTONS = 16,
  parameter int USER_W      = 16,
  parameter int SCAN_W      = 8,
  parameter int KEY_W       = 10,
  parameter int REP_W       = 8,
  localparam int GRP_W      = $clog2(NUM_GROUPS),
  localparam int IDX_W      = $clog2(MAX_BUTTONS),
  localparam int CFG_W      = (USER_W > SCAN_W + KEY_W) ? USER_W : SCAN_W + KEY_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgWe,
  input  logic [1:0]        cfgKind,
  input  logic [GRP_W-1:0]  cfgGroup,
  input  logic [IDX_W-1:0]  cfgSlot,
  input  logic [CFG_W-1:0]  cfgData,
  input  logic              reqValid,
  input  logic [USER_W-1:0] reqUser,
  input  logic [SCAN_W-1:0] reqScan,
  output logic              busy,
  output logic              done,
  output logic              hit,
  output logic [KEY_W-1:0]  keyCode,
  output logic [REP_W-1:0]  repeatCnt
);

  strobes_t strobes;
  flags_t   flags;

  irKeymapCtrl #(
    .NUM_GROUPS (NUM_GROUPS),
    .MAX_BUTTONS(MAX_BUTTONS)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .reqValid(reqValid),
    .flags   (flags),
    .strobes (strobes),
    .busy    (busy)
  );

  irKeymapData #(
    .NUM_GROUPS (NUM_GROUPS),
    .MAX_BUTTONS(MAX_BUTTONS),
    .USER_W     (USER_W),
    .SCAN_W     (SCAN_W),
    .KEY_W      (KEY_W),
    .REP_W      (REP_W)
  ) u_data (
    .clk      (clk),
    .rst      (rst),
    .cfgWe    (cfgWe),
    .cfgKind  (cfgKind),
    .cfgGroup (cfgGroup),
    .cfgSlot  (cfgSlot),
    .cfgData  (cfgData),
    .reqUser  (reqUser),
    .reqScan  (reqScan),
    .strobes  (strobes),
    .flags    (flags),
    .done     (done),
    .hit      (hit),
    .keyCode  (keyCode),
    .repeatCnt(repeatCnt)
  );

endmodule

// File: tb/irKeymap_tb.sv
module irKeymap_tb;

  localparam int NG = 4;
  localparam int NB = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgKind = 2'd0;
  logic [1:0]  cfgGroup = 2'd0;
  logic [3:0]  cfgSlot = 4'd0;
  logic [17:0] cfgData = '0;
  logic        reqValid = 1'b0;
  logic [15:0] reqUser = '0;
  logic [7:0]  reqScan = '0;
  logic        busy, done, hit;
  logic [9:0]  keyCode;
  logic [7:0]  repeatCnt;

  int total = 0;
  int bad = 0;

  // Model of the table, kept from the written values per the requirements
  int mUser [NG];
  int mCnt  [NG];
  int mScan [NG][NB];
  int mKey  [NG][NB];
  int prevKey = 0;
  int prevRep = 0;

  always #4 clk = ~clk;

  irKeymap u_dut (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgKind(cfgKind), .cfgGroup(cfgGroup),
    .cfgSlot(cfgSlot), .cfgData(cfgData), .reqValid(reqValid), .reqUser(reqUser),
    .reqScan(reqScan), .busy(busy), .done(done), .hit(hit), .keyCode(keyCode),
    .repeatCnt(repeatCnt)
  );

  task automatic chkEq(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int userOf(input int g);
    return 16'h1000 * (g + 1) + 16'h0035 * g + 16'h00A5;
  endfunction
  function automatic int scanOf(input int g, input int s);
    return (s * 17 + g * 3 + 5) & 255;
  endfunction
  function automatic int keyOf(input int g, input int s);
    return g * 100 + s * 7 + 3;
  endfunction

  task automatic cfgWrite(input int kind, input int grp, input int slot, input int data);
    @(negedge clk);
    cfgWe = 1'b1; cfgKind = 2'(kind); cfgGroup = 2'(grp); cfgSlot = 4'(slot); cfgData = 18'(data);
    @(negedge clk);
    cfgWe = 1'b0;
    case (kind)
      0: if ((data & 16'hFFFF) != 0) mUser[grp] = data & 16'hFFFF;
      1: mCnt[grp] = (data > NB) ? NB : data;
      2: begin
        mScan[grp][slot] = data & 255;
        mKey[grp][slot]  = (data >> 8) & 1023;
      end
      default: ;
    endcase
  endtask

  // One lookup; poke raises a second request while busy (R9)
  task automatic lookup(input int u, input int s, input bit poke, input string req);
    int expKey, expHit, expRep, expLat, grpFound;
    int n;
    expKey = 0; expHit = 0; expLat = NG; grpFound = -1;
    for (int g = 0; g < NG; g++) begin
      if (grpFound < 0 && u != 0 && mUser[g] == u) grpFound = g;
    end
    if (grpFound >= 0) begin
      expLat = grpFound + 1 + mCnt[grpFound] + 1;
      for (int j = mCnt[grpFound] - 1; j >= 0; j--) begin
        if (mScan[grpFound][j] == s) begin
          expHit = 1;
          expKey = mKey[grpFound][j];
          expLat = grpFound + 1 + j + 1;
        end
      end
    end
    if (expHit == 1) expRep = (expKey == prevKey) ? ((prevRep == 255) ? 255 : prevRep + 1) : 0;
    else expRep = 0;

    @(negedge clk);
    reqValid = 1'b1; reqUser = 16'(u); reqScan = 8'(s);
    @(posedge clk);
    @(negedge clk);
    chkEq("R8", "busy after accept", int'(busy), 1);
    reqValid = poke;
    if (poke) begin
      reqUser = 16'(u ^ 16'h0F0F);
      reqScan = 8'(s ^ 8'h5A);
    end
    n = 0;
    while (1) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      reqValid = 1'b0;
      if (done || n > 60) break;
    end
    chkEq(req, "latency", n, expLat);
    chkEq(req, "keyCode", int'(keyCode), expKey);
    chkEq(req, "hit", int'(hit), expHit);
    chkEq(req, "repeatCnt", int'(repeatCnt), expRep);
    chkEq("R8", "busy at done", int'(busy), 0);
    @(posedge clk);
    @(negedge clk);
    chkEq("R8", "done one cycle", int'(done), 0);
    if (poke) chkEq("R9", "stays idle after poke", int'(busy), 0);
    prevKey = expKey;
    prevRep = expRep;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int g = 0; g < NG; g++) begin
      mUser[g] = 0; mCnt[g] = 0;
      for (int s = 0; s < NB; s++) begin mScan[g][s] = 0; mKey[g][s] = 0; end
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chkEq("R1", "busy", int'(busy), 0);
    chkEq("R1", "done", int'(done), 0);
    chkEq("R1", "hit", int'(hit), 0);
    chkEq("R1", "keyCode", int'(keyCode), 0);
    chkEq("R1", "repeatCnt", int'(repeatCnt), 0);

    // R3 empty groups never match, not even user code 0
    lookup(16'h1234, 8'h10, 1'b0, "R3");
    lookup(0, 0, 1'b0, "R3");

    // R2 load table: counts 16, 11, 21 (stored as 16), 0
    for (int g = 0; g < NG; g++) begin
      cfgWrite(0, g, 0, userOf(g));
      for (int s = 0; s < NB; s++) cfgWrite(2, g, s, (keyOf(g, s) << 8) | scanOf(g, s));
    end
    cfgWrite(1, 0, 0, 16);
    cfgWrite(1, 1, 0, 11);
    cfgWrite(1, 2, 0, 21);
    cfgWrite(1, 3, 0, 0);
    cfgWrite(3, 0, 5, 18'h3FFFF);  // R2 kind 3 has no effect

    // R4 R5 R7 sweep every slot of every group
    for (int g = 0; g < NG; g++)
      for (int s = 0; s < NB; s++)
        lookup(userOf(g), scanOf(g, s), 1'b0, "R4");

    // R4 scan code of another group is not found in this one
    lookup(userOf(1), scanOf(0, 2), 1'b0, "R4");

    // R6 repeat counting up to saturation, then reset on new key
    for (int i = 0; i < 260; i++) lookup(userOf(2), scanOf(2, 4), 1'b0, "R6");
    chkEq("R6", "saturated", int'(repeatCnt), 255);
    lookup(userOf(2), scanOf(2, 5), 1'b0, "R6");
    lookup(userOf(2), scanOf(2, 5), 1'b0, "R6");
    lookup(userOf(2), 8'hFF, 1'b0, "R7");
    lookup(userOf(2), scanOf(2, 5), 1'b0, "R6");

    // R3 a zero user-code write is ignored
    cfgWrite(0, 2, 0, 0);
    lookup(userOf(2), scanOf(2, 7), 1'b0, "R3");

    // R9 request during busy is ignored
    lookup(userOf(1), scanOf(1, 9), 1'b1, "R9");
    lookup(userOf(3), scanOf(3, 0), 1'b1, "R9");

    // R4 duplicate user code: only the first group is searched
    cfgWrite(0, 1, 0, userOf(0));
    lookup(userOf(0), scanOf(1, 0), 1'b0, "R4");
    lookup(userOf(0), scanOf(0, 3), 1'b0, "R4");

    // R7 unknown user code
    lookup(16'hBEEF, scanOf(0, 3), 1'b0, "R7");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule